// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block stores one received Ethernet frame into a single packet page of a shared buffer memory. A frame is offered as a length on a valid/ready handshake. Its bytes follow on a second valid/ready byte stream. The block checks the receive controls, asks the page allocator for a page, and then writes a fixed layout into that page, one byte per cycle: a 16-bit status word, a 16-bit stored byte count, the frame data zero-padded to the minimum frame size, an optional CRC-32, and a closing control word. When the last byte has been written, the page number is pushed onto the receive queue and a one-cycle receive event is raised.

Back-pressure rules: `frm_ready` is high only while the block is idle, and a frame counts as accepted on a cycle with `frm_valid` and `frm_ready` both high. `byte_ready` is high only in cycles where the block can take a byte. A byte counts as transferred on a cycle with `byte_valid` and `byte_ready` both high. The source may hold `byte_valid` low for any number of cycles, and the block then waits. Exactly `frm_len` bytes are taken for every accepted frame, including a dropped one. Padding bytes are generated inside the block and take nothing from the stream. The page write port has no back-pressure.

The allocator answers in the same cycle that `alloc_req` is high. It returns a page number on `alloc_page`, or the code 0x80 when no page is free.

Top module: `rxw_frame_writer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `busy` is low and `frm_ready` is high. While a frame is being handled, `busy` is high and `frm_ready` is low, and every page write happens while `busy` is high.
- R2: `rx_en` and `soft_rst` are sampled only in the acceptance cycle. If `rx_en` is low or `soft_rst` is high at that point, the frame's bytes are consumed with no page write, no allocation request and no push. Changing them after acceptance has no effect on the frame.
- R3: A frame that passes R2 and R4 raises `alloc_req` for exactly one cycle. If `alloc_page` equals 0x80 in that cycle, the frame's bytes are consumed with no write and no push.
- R4: Let S be `frm_len` raised to at least 64. The stored count is S rounded down to even, plus 6, plus 4 unless `strip_crc` was set at acceptance. If this count exceeds 2048, the frame is dropped without an allocation request. Otherwise exactly that many bytes are written.
- R5: Page offsets 0 and 1 hold the status word, low byte first. Bit 11 is set when S > 1518, bit 12 is set when S is odd, and all other bits are zero. Offsets 2 and 3 hold the stored count, low byte first.
- R6: From offset 4, the first even(S) frame bytes are written in arrival order. Positions at or beyond `frm_len` are written as zero.
- R7: Unless `strip_crc` is set, the next 4 bytes are the Ethernet CRC-32 of all S (padded) bytes: reflected polynomial 0xEDB88320, seed all ones, result inverted, stored least significant byte first.
- R8: The last two bytes of the page image are the closing word. For odd S, the first byte is the final frame byte, placed after the CRC, and the second byte is 0x60. For even S, they are 0x00 and 0x40.
- R9: In the cycle after the last write, `q_push` and `rx_event` are high together for one cycle, with `q_page` equal to the granted page.
- R10: Writes of one frame start at offset 0, use consecutive offsets, and keep `wr_page` equal to the granted page throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame length offered |
| frm_ready | output | 1 | Block can accept a frame |
| frm_len | input | 12 | Frame length in bytes |
| byte_valid | input | 1 | Stream byte offered |
| byte_ready | output | 1 | Block can take a stream byte |
| byte_data | input | 8 | Stream byte |
| rx_en | input | 1 | Receive enable |
| soft_rst | input | 1 | Soft reset active |
| strip_crc | input | 1 | Do not store the CRC |
| alloc_req | output | 1 | Page request to allocator |
| alloc_page | input | 8 | Granted page, 0x80 on failure |
| wr_en | output | 1 | Page write strobe |
| wr_page | output | 8 | Page being written |
| wr_addr | output | 11 | Byte offset inside the page |
| wr_data | output | 8 | Byte written |
| q_push | output | 1 | Push page onto receive queue |
| q_page | output | 8 | Page number pushed |
| rx_event | output | 1 | Receive event pulse |
| busy | output | 1 | Frame in progress |

## Verification
The receive controls are sampled in the acceptance cycle, and a change to them in a later cycle must not alter the frame. The bench lowers `rx_en` on the edge right after the frame handshake and expects the complete page image and push. Stream stalls coincide with the data phase, where the block either waits for a byte or writes generated padding. Random idle gaps on `byte_valid` over short and odd lengths provoke this, and the bench judges the result by comparing the captured page with an image built from R4 to R8.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ALLOC, S_HDR, S_DATA, S_LAST, S_CRC, S_TAIL, S_DONE, S_DROP
  } rxw_state_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [7:0]  CTL_ODD  = 8'h60;
  localparam logic [7:0]  CTL_EVEN = 8'h40;

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rxw_crc.sv
module rxw_crc import rxw_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  logic [31:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '1;
    else if (clr) acc <= '1;
    else if (en)  acc <= crc_step(acc, din);
  end

  assign crc_out = ~acc;
endmodule

// File: rtl/rxw_seq.sv
module rxw_seq import rxw_pkg::*; #(
  parameter int PAGE_BYTES = 2048,
  parameter int LEN_W      = 12,
  parameter int PNUM_W     = 8,
  parameter int MIN_LEN    = 64,
  parameter int LONG_LEN   = 1518,
  parameter int FAIL_CODE  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [7:0]        byte_data,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic              strip_crc,
  output logic              alloc_req,
  input  logic [PNUM_W-1:0] alloc_page,
  output logic              wr_en,
  output logic [PNUM_W-1:0] wr_page,
  output logic [$clog2(PAGE_BYTES)-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              q_push,
  output logic [PNUM_W-1:0] q_page,
  output logic              rx_event,
  output logic              busy,
  output logic              crc_clr,
  output logic              crc_en,
  output logic [7:0]        crc_din,
  input  logic [31:0]       crc_val
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = LEN_W + 1;

  rxw_state_e st;
  logic [LEN_W-1:0]  len_q, even_q, idx;
  logic [CNT_W-1:0]  count_q;
  logic [PNUM_W-1:0] page_q;
  logic [OFF_W-1:0]  off;
  logic [7:0]        last_q;
  logic              odd_q, long_q, strip_q;

  // acceptance-time size arithmetic
  logic [LEN_W-1:0] acc_size, acc_even;
  logic [CNT_W-1:0] acc_cnt;
  logic             acc_ok;
  always_comb begin
    acc_size = (frm_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : frm_len;
    acc_even = {acc_size[LEN_W-1:1], 1'b0};
    acc_cnt  = CNT_W'(acc_even) + CNT_W'(6) + (strip_crc ? CNT_W'(0) : CNT_W'(4));
    acc_ok   = rx_en && !soft_rst && (acc_cnt <= CNT_W'(PAGE_BYTES));
  end

  logic [15:0] stat_w, cnt_w;
  logic        need, step;
  assign stat_w = {3'b000, odd_q, long_q, 11'd0};
  assign cnt_w  = 16'(count_q);
  assign need   = idx < len_q;

  always_comb begin
    frm_ready = 1'b0; byte_ready = 1'b0; alloc_req = 1'b0;
    wr_en = 1'b0; wr_data = 8'd0; q_push = 1'b0; rx_event = 1'b0;
    crc_en = 1'b0; crc_din = 8'd0; step = 1'b0;
    unique case (st)
      S_IDLE:  frm_ready = 1'b1;
      S_ALLOC: alloc_req = 1'b1;
      S_HDR: begin
        wr_en = 1'b1;
        case (idx[1:0])
          2'd0: wr_data = stat_w[7:0];
          2'd1: wr_data = stat_w[15:8];
          2'd2: wr_data = cnt_w[7:0];
          default: wr_data = cnt_w[15:8];
        endcase
      end
      S_DATA: begin
        if (need) begin
          byte_ready = 1'b1;
          step       = byte_valid;
          wr_data    = byte_data;
        end else begin
          step = 1'b1;
        end
        wr_en   = step;
        crc_en  = step;
        crc_din = wr_data;
      end
      S_LAST: begin
        byte_ready = 1'b1;
        crc_en     = byte_valid;
        crc_din    = byte_data;
      end
      S_CRC: begin
        wr_en   = 1'b1;
        wr_data = crc_val[8*idx[1:0] +: 8];
      end
      S_TAIL: begin
        wr_en   = 1'b1;
        if (idx[0]) wr_data = odd_q ? CTL_ODD : CTL_EVEN;
        else        wr_data = odd_q ? last_q : 8'd0;
      end
      S_DONE: begin
        q_push   = 1'b1;
        rx_event = 1'b1;
      end
      S_DROP:  byte_ready = 1'b1;
      default: ;
    endcase
  end

  assign crc_clr = frm_valid && frm_ready;
  assign busy    = (st != S_IDLE);
  assign wr_page = page_q;
  assign q_page  = page_q;
  assign wr_addr = off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; len_q <= '0; even_q <= '0; idx <= '0; count_q <= '0;
      page_q <= '0; off <= '0; last_q <= '0; odd_q <= 1'b0; long_q <= 1'b0;
      strip_q <= 1'b0;
    end else begin
      if (st == S_IDLE) off <= '0;
      else if (wr_en)   off <= off + 1'b1;
      unique case (st)
        S_IDLE: if (frm_valid) begin
          len_q   <= frm_len;
          even_q  <= acc_even;
          odd_q   <= acc_size[0];
          long_q  <= acc_size > LEN_W'(LONG_LEN);
          strip_q <= strip_crc;
          count_q <= acc_cnt;
          idx     <= '0;
          if (acc_ok)              st <= S_ALLOC;
          else if (frm_len != '0)  st <= S_DROP;
        end
        S_ALLOC: begin
          page_q <= alloc_page;
          if (alloc_page != PNUM_W'(FAIL_CODE)) st <= S_HDR;
          else if (len_q != '0)                 st <= S_DROP;
          else                                  st <= S_IDLE;
        end
        S_HDR: begin
          idx <= (idx[1:0] == 2'd3) ? '0 : idx + 1'b1;
          if (idx[1:0] == 2'd3) st <= S_DATA;
        end
        S_DATA: if (step) begin
          if (idx == even_q - 1'b1) begin
            idx <= '0;
            st  <= odd_q ? S_LAST : (strip_q ? S_TAIL : S_CRC);
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_LAST: if (byte_valid) begin
          last_q <= byte_data;
          st     <= strip_q ? S_TAIL : S_CRC;
        end
        S_CRC: begin
          idx <= (idx[1:0] == 2'd3) ? '0 : idx + 1'b1;
          if (idx[1:0] == 2'd3) st <= S_TAIL;
        end
        S_TAIL: begin
          idx <= idx + 1'b1;
          if (idx[0]) begin
            st  <= S_DONE;
            idx <= '0;
          end
        end
        S_DONE: st <= S_IDLE;
        S_DROP: if (byte_valid) begin
          idx <= idx + 1'b1;
          if (idx == len_q - 1'b1) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxw_frame_writer.sv
module rxw_frame_writer import rxw_pkg::*; #(
  parameter int PAGE_BYTES = 2048,
  parameter int LEN_W      = 12,
  parameter int PNUM_W     = 8,
  parameter int MIN_LEN    = 64,
  parameter int LONG_LEN   = 1518,
  parameter int FAIL_CODE  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [7:0]        byte_data,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic              strip_crc,
  output logic              alloc_req,
  input  logic [PNUM_W-1:0] alloc_page,
  output logic              wr_en,
  output logic [PNUM_W-1:0] wr_page,
  output logic [$clog2(PAGE_BYTES)-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              q_push,
  output logic [PNUM_W-1:0] q_page,
  output logic              rx_event,
  output logic              busy
);
  logic        crc_clr, crc_en;
  logic [7:0]  crc_din;
  logic [31:0] crc_val;

  rxw_seq #(
    .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W), .PNUM_W(PNUM_W),
    .MIN_LEN(MIN_LEN), .LONG_LEN(LONG_LEN), .FAIL_CODE(FAIL_CODE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_len(frm_len),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .rx_en(rx_en), .soft_rst(soft_rst), .strip_crc(strip_crc),
    .alloc_req(alloc_req), .alloc_page(alloc_page),
    .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
    .q_push(q_push), .q_page(q_page), .rx_event(rx_event), .busy(busy),
    .crc_clr(crc_clr), .crc_en(crc_en), .crc_din(crc_din), .crc_val(crc_val)
  );

  rxw_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .din(crc_din), .crc_out(crc_val)
  );
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
  parameter int PAGE_BYTES = 2048,
  parameter int PNUM_W     = 8,
  parameter int FAIL_CODE  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_ready,
  input logic              busy,
  input logic              alloc_req,
  input logic [PNUM_W-1:0] alloc_page,
  input logic              wr_en,
  input logic [PNUM_W-1:0] wr_page,
  input logic [$clog2(PAGE_BYTES)-1:0] wr_addr,
  input logic              q_push,
  input logic              rx_event
);
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !frm_ready); // R1
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy); // R1
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_page == PNUM_W'(FAIL_CODE)) |=> (!wr_en && !q_push)); // R3
  AST_ALLOC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> !alloc_req); // R3
  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> !q_push); // R9
  AST_EVENT_WITH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |-> q_push); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1)); // R10
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> $stable(wr_page)); // R10
endmodule

bind rxw_frame_writer rxw_checker #(
  .PAGE_BYTES(PAGE_BYTES), .PNUM_W(PNUM_W), .FAIL_CODE(FAIL_CODE)
) u_rxw_chk (
  .clk(clk), .rst_n(rst_n), .frm_ready(frm_ready), .busy(busy),
  .alloc_req(alloc_req), .alloc_page(alloc_page), .wr_en(wr_en),
  .wr_page(wr_page), .wr_addr(wr_addr), .q_push(q_push), .rx_event(rx_event)
);

// File: tb/tb_rxw_frame_writer.sv
module tb_rxw_frame_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0, byte_valid = 1'b0;
  logic [11:0] frm_len = '0;
  logic [7:0]  byte_data = '0;
  logic        rx_en = 1'b1, soft_rst = 1'b0, strip_crc = 1'b0;
  logic        fail_alloc = 1'b0;
  logic [7:0]  next_page = 8'd5;
  logic [7:0]  alloc_page;
  logic        frm_ready, byte_ready, alloc_req, wr_en, q_push, rx_event, busy;
  logic [7:0]  wr_page, wr_data, q_page;
  logic [10:0] wr_addr;

  assign alloc_page = fail_alloc ? 8'h80 : next_page;

  rxw_frame_writer dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .rx_en(rx_en), .soft_rst(soft_rst),
    .strip_crc(strip_crc), .alloc_req(alloc_req), .alloc_page(alloc_page),
    .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
    .q_push(q_push), .q_page(q_page), .rx_event(rx_event), .busy(busy)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int cap [2048];
  int expb [2048];
  int frame [4096];
  int pad [4096];
  int nwr, npush, nevt, nalloc, addr_bad, page_bad, pushed;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (wr_en) begin
      if (int'(wr_addr) != nwr) addr_bad = 1;
      if (wr_page != next_page) page_bad = 1;
      cap[wr_addr] = wr_data;
      nwr++;
    end
    if (q_push) begin npush++; pushed = q_page; end
    if (rx_event) nevt++;
    if (alloc_req) nalloc++;
  end

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ 32'(pad[i]);
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // builds expected page image, returns byte count (R4..R8)
  function automatic int build_exp(int len, bit strip);
    int sz, ev, cnt, p, st;
    logic [31:0] c;
    sz = (len < 64) ? 64 : len;
    ev = sz & ~1;
    cnt = ev + 6 + (strip ? 0 : 4);
    for (int i = 0; i < sz; i++) pad[i] = (i < len) ? frame[i] : 0;
    st = ((sz > 1518) ? 16'h0800 : 0) | ((sz % 2) ? 16'h1000 : 0);
    expb[0] = st & 255; expb[1] = st >> 8;
    expb[2] = cnt & 255; expb[3] = cnt >> 8;
    for (int i = 0; i < ev; i++) expb[4 + i] = pad[i];
    p = 4 + ev;
    if (!strip) begin
      c = ref_crc(sz);
      for (int b = 0; b < 4; b++) expb[p + b] = int'((c >> (8 * b)) & 32'hFF);
      p += 4;
    end
    if (sz % 2) begin expb[p] = pad[sz - 1]; expb[p + 1] = 8'h60; end
    else        begin expb[p] = 0;           expb[p + 1] = 8'h40; end
    return cnt;
  endfunction

  task automatic run_frame(input int len, input bit strip, input bit en,
                           input bit srst, input bit fail, input bit toggle,
                           input string req);
    int cnt, bad_i;
    bit drop;
    for (int i = 0; i < len; i++) frame[i] = int'($urandom % 256);
    cnt = build_exp(len, strip);
    drop = !en || srst || fail || (cnt > 2048);
    nwr = 0; npush = 0; nevt = 0; nalloc = 0; addr_bad = 0; page_bad = 0;
    @(posedge clk); #1;
    rx_en = en; soft_rst = srst; strip_crc = strip; fail_alloc = fail;
    frm_len = 12'(len); frm_valid = 1'b1;
    do @(negedge clk); while (!frm_ready);
    @(posedge clk); #1;
    frm_valid = 1'b0;
    if (toggle) begin rx_en = 1'b0; soft_rst = 1'b1; strip_crc = ~strip; end
    for (int i = 0; i < len; i++) begin
      repeat ($urandom % 3) begin @(posedge clk); #1; end
      byte_valid = 1'b1; byte_data = 8'(frame[i]);
      do @(negedge clk); while (!byte_ready);
      @(posedge clk); #1;
      byte_valid = 1'b0;
    end
    do @(negedge clk); while (busy);
    @(negedge clk);
    if (drop) begin
      chk(nwr == 0, {req, " dropped frame writes"}, nwr, 0);
      chk(npush == 0 && nevt == 0, {req, " dropped frame push"}, npush, 0);
      chk(nalloc == ((fail) ? 1 : 0), {req, " allocation requests"}, nalloc, fail ? 1 : 0);
    end else begin
      chk(nwr == cnt, {req, " R4 byte count"}, nwr, cnt);
      bad_i = -1;
      for (int i = 0; i < cnt; i++) if (bad_i < 0 && cap[i] != expb[i]) bad_i = i;
      chk(bad_i < 0, {req, " page image (R5-R8 layout) first bad offset"}, bad_i,
          (bad_i < 0) ? -1 : expb[bad_i]);
      chk(npush == 1 && nevt == 1 && pushed == int'(next_page),
          {req, " R9 push/event page"}, pushed, int'(next_page));
      chk(addr_bad == 0 && page_bad == 0, {req, " R10 offsets and page"}, addr_bad, 0);
    end
    rx_en = 1'b1; soft_rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && frm_ready && !wr_en && !q_push, "R1 reset state", busy, 0);
    run_frame(10,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 R7 short padded");
    run_frame(0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 empty frame");
    run_frame(64,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7 strip crc");
    next_page = 8'd17;
    run_frame(65,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 odd length");
    run_frame(1519, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 too long odd");
    run_frame(2042, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 exactly full page");
    run_frame(2043, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 oversize drop");
    run_frame(20,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 receive disabled");
    run_frame(5,    1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R2 soft reset");
    run_frame(30,   1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R3 allocation failure");
    run_frame(70,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2 controls changed after accept");
    for (int n = 0; n < 10; n++) begin
      next_page = 8'($urandom % 64);
      run_frame(1 + int'($urandom % 200), 1'($urandom % 2), 1'b1, 1'b0, 1'b0, 1'b0,
                "R6 R7 R8 random frame");
    end
    @(negedge clk);
    chk(!busy && frm_ready, "R1 idle after traffic", busy, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule